// File: doc/BRIEF.md
# Indexed Configuration Port with Shadow Window Decode

This block holds a chipset's configuration registers behind a pair of I/O ports. One port latches a register index and the other moves data to or from the selected register. One index value behaves differently from the rest. It gives ordered access to two concealed control bytes through a small access counter, and that counter moves forward on every data access.

The two concealed bytes set where the upper BIOS region of memory is served from. When the second concealed byte is written, the block loads a new mapping. From that mapping and a 20-bit memory address, a decoder reports for each access whether a read or a write should go to on-chip shadow RAM or to the external bus. Data-port reads are combinational on the current state. Every state change takes effect at the rising clock edge on which a strobe is sampled.

Top module: `cfg_shadow_port`

## Requirements
- R1: After reset, every register, the index and the counter are zero. The applied mapping is the 64 KiB window, with both flags low for every address.
- R2: Index 0x22 is the index port and 0x23 is the data port. For any index other than 0x83, a data write stores into the ordinary register at that index and a data read returns that register. The access counter is left unchanged.
- R3: A write to the index port stores the index and clears the counter. Reads of the index port, and reads of any address other than 0x22 and 0x23, return 0xFF. Writes to any other address change nothing.
- R4: While the index is 0x83, each data access reaches concealed byte 0 when the counter is 0 and concealed byte 1 when the counter is 1. A read and a write both advance the counter by one.
- R5: While the index is 0x83 and the counter is 2, data writes are ignored and data reads return 0xFF.
- R6: A new mapping is taken only on the edge that completes the write of concealed byte 1, and it is visible from the next cycle. Writing concealed byte 0 alone leaves the flags unchanged.
- R7: Bit 1 of concealed byte 0 enables shadow writes, and bit 6 of concealed byte 1 enables shadow reads. Inside the window, the write flag follows the first and the read flag follows the second.
- R8: Bit 3 of concealed byte 0 selects the window: clear means 0xF0000–0xFFFFF, set means 0xE0000–0xFFFFF. Bit 0 has no effect on the mapping.
- R9: For an address outside the active window, both flags are low.
- R10: A read strobe and a write strobe on the data port in the same cycle under index 0x83 advance the counter once. The read returns the slot's old contents and the write stores into that same slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 8 | Low byte of the I/O address |
| io_wr | input | 1 | I/O write strobe, one transfer per cycle it is high |
| io_rd | input | 1 | I/O read strobe, one transfer per cycle it is high |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, 0xFF unless a data-port read hits a register |
| mem_addr | input | 20 | Memory address to classify |
| shadow_rd_int | output | 1 | Read at mem_addr is served from shadow RAM |
| shadow_wr_int | output | 1 | Write at mem_addr is served from shadow RAM |

## Verification
The decoder and the commit of a new mapping can fall in the same cycle. The bench holds an address inside the window while the second concealed byte is being written. It checks that the flags still show the old mapping before the edge and show the new one after it. A read strobe and a write strobe on the data port can also coincide. The bench raises both under index 0x83 and judges the result three ways: the returned byte must be the slot's old value, the written byte must appear on a later read, and the second concealed slot must still be reachable.

// File: rtl/cfg_shadow_pkg.sv
package cfg_shadow_pkg;
  localparam int DW       = 8;
  localparam int IO_AW    = 8;
  localparam int MEM_AW   = 20;

  localparam logic [IO_AW-1:0] PORT_INDEX = 8'h22;
  localparam logic [IO_AW-1:0] PORT_DATA  = 8'h23;
  localparam logic [DW-1:0]    IDX_HIDDEN = 8'h83;

  // bit positions inside the concealed bytes
  localparam int H0_WREN_BIT = 1;
  localparam int H0_WIN_BIT  = 3;
  localparam int H1_RDEN_BIT = 6;

  typedef struct packed {
    logic win128;
    logic rd_en;
    logic wr_en;
  } shadow_map_t;

  localparam shadow_map_t MAP_RESET = '{win128: 1'b0, rd_en: 1'b0, wr_en: 1'b0};
endpackage

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
  parameter int DW       = 8,
  parameter int NUM_REGS = 256,
  localparam int AW      = $clog2(NUM_REGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] regs_q [NUM_REGS];

  genvar g;
  generate
    for (g = 0; g < NUM_REGS; g++) begin : g_reg
      logic          hit;
      logic [DW-1:0] d;
      always_comb begin
        hit = wr_en && (addr == AW'(g));
        d   = hit ? wdata : regs_q[g];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   regs_q[g] <= '0;
        else if (hit) regs_q[g] <= d;
      end
    end
  endgenerate

  assign rdata = regs_q[addr];

  // R2: a written ordinary register reads back its value next cycle
  a_r2_store: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (regs_q[$past(addr)] == $past(wdata)));
endmodule

// File: rtl/cfg_index_seq.sv
module cfg_index_seq
  import cfg_shadow_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idx_wr,
  input  logic          data_wr,
  input  logic          data_rd,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] idx,
  output logic          hidden_sel,
  output logic [DW-1:0] hid_rdata,
  output logic [DW-1:0] hid0,
  output logic          commit
);
  localparam int CNT_W  = 2;
  localparam int SLOTS  = 2;

  logic [DW-1:0]    idx_q, idx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DW-1:0]    hid_q [SLOTS];
  logic             slot_open, advance, hid_we;

  always_comb begin
    hidden_sel = (idx_q == IDX_HIDDEN);
    slot_open  = hidden_sel && (cnt_q < CNT_W'(SLOTS));
    advance    = slot_open && (data_wr || data_rd);
    hid_we     = slot_open && data_wr;
    commit     = hid_we && (cnt_q == CNT_W'(SLOTS - 1));
    hid_rdata  = slot_open ? hid_q[cnt_q[0]] : '1;
    idx_d      = idx_wr ? wdata : idx_q;
    if (idx_wr)       cnt_d = '0;
    else if (advance) cnt_d = cnt_q + 1'b1;
    else              cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      cnt_q <= '0;
    end else begin
      if (idx_wr)            idx_q <= idx_d;
      if (idx_wr || advance) cnt_q <= cnt_d;
    end
  end

  genvar s;
  generate
    for (s = 0; s < SLOTS; s++) begin : g_hid
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          hid_q[s] <= '0;
        else if (hid_we && cnt_q[0] == s[0]) hid_q[s] <= wdata;
      end
    end
  endgenerate

  assign idx  = idx_q;
  assign hid0 = hid_q[0];

  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(SLOTS));
  a_r3_idx_clears: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> (cnt_q == '0));
  a_r2_cnt_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (!idx_wr && !hidden_sel) |=> $stable(cnt_q));
  a_r5_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (hidden_sel && cnt_q == CNT_W'(SLOTS) && !idx_wr) |=> ($stable(hid_q[0]) && $stable(hid_q[1])));
  a_r10_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    (hidden_sel && data_wr && data_rd && cnt_q == '0 && !idx_wr) |=> (cnt_q == 2'd1));
endmodule

// File: rtl/shadow_window_dec.sv
module shadow_window_dec
  import cfg_shadow_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  shadow_map_t       map_in,
  input  logic [MEM_AW-1:0] mem_addr,
  output logic              rd_int,
  output logic              wr_int
);
  localparam int TOP_W = 4;   // 64 KiB granularity in a 1 MiB space

  shadow_map_t map_q;
  logic [TOP_W-1:0] seg;
  logic in_win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    map_q <= MAP_RESET;
    else if (load) map_q <= map_in;
  end

  always_comb begin
    seg    = mem_addr[MEM_AW-1 -: TOP_W];
    in_win = map_q.win128 ? (seg[TOP_W-1:1] == '1) : (seg == '1);
    rd_int = in_win && map_q.rd_en;
    wr_int = in_win && map_q.wr_en;
  end

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(map_q));
  a_r9_outside: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr[MEM_AW-1 -: 3] != 3'b111) |-> (!rd_int && !wr_int));
endmodule

// File: rtl/cfg_shadow_port.sv
module cfg_shadow_port
  import cfg_shadow_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  io_addr,
  input  logic        io_wr,
  input  logic        io_rd,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  input  logic [19:0] mem_addr,
  output logic        shadow_rd_int,
  output logic        shadow_wr_int
);
  localparam int NUM_REGS = 1 << DW;

  logic          idx_wr, data_wr, data_rd;
  logic [DW-1:0] idx, hid_rdata, hid0, bank_rdata;
  logic          hidden_sel, commit;
  shadow_map_t   map_next;

  always_comb begin
    idx_wr  = io_wr && (io_addr == PORT_INDEX);
    data_wr = io_wr && (io_addr == PORT_DATA);
    data_rd = io_rd && (io_addr == PORT_DATA);
  end

  cfg_index_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx_wr    (idx_wr),
    .data_wr   (data_wr),
    .data_rd   (data_rd),
    .wdata     (io_wdata),
    .idx       (idx),
    .hidden_sel(hidden_sel),
    .hid_rdata (hid_rdata),
    .hid0      (hid0),
    .commit    (commit)
  );

  cfg_reg_bank #(.DW(DW), .NUM_REGS(NUM_REGS)) u_bank (
    .clk  (clk),
    .rst_n(rst_n),
    .wr_en(data_wr && !hidden_sel),
    .addr (idx),
    .wdata(io_wdata),
    .rdata(bank_rdata)
  );

  always_comb begin
    map_next.win128 = hid0[H0_WIN_BIT];
    map_next.wr_en  = hid0[H0_WREN_BIT];
    map_next.rd_en  = io_wdata[H1_RDEN_BIT];
  end

  shadow_window_dec u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (commit),
    .map_in  (map_next),
    .mem_addr(mem_addr),
    .rd_int  (shadow_rd_int),
    .wr_int  (shadow_wr_int)
  );

  always_comb begin
    if (!data_rd)        io_rdata = 8'hFF;
    else if (hidden_sel) io_rdata = hid_rdata;
    else                 io_rdata = bank_rdata;
  end

  a_r3_idx_read_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr != PORT_DATA) |-> (io_rdata == 8'hFF));
endmodule

// File: tb/cfg_shadow_port_test.sv
module cfg_shadow_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  io_addr = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic [19:0] mem_addr = '0;
  logic        shadow_rd_int, shadow_wr_int;

  always #4 clk = ~clk;   // 125 MHz

  cfg_shadow_port uut (.*);

  typedef struct {
    bit        is_flags;   // 0: io_rdata, 1: {rd_int, wr_int}
    logic [7:0] exp;
    string     req;
  } exp_item_t;

  exp_item_t sb[$];
  int checks = 0, failures = 0;
  bit done = 0;

  // monitor: compare queued expectations 2 ns after each falling edge
  initial forever begin
    @(negedge clk);
    #2;
    while (sb.size() > 0) begin
      exp_item_t it;
      logic [7:0] act;
      it  = sb.pop_front();
      act = it.is_flags ? {6'b0, shadow_rd_int, shadow_wr_int} : io_rdata;
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s actual=%02h expected=%02h", it.req, act, it.exp);
      end
    end
  end

  task automatic push(bit f, logic [7:0] e, string r);
    exp_item_t it;
    it.is_flags = f; it.exp = e; it.req = r;
    sb.push_back(it);
  endtask

  task automatic io_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(logic [7:0] a, logic [7:0] e, string r);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1 push(0, e, r);
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic map_check(logic [19:0] a, logic [1:0] e, string r);
    @(negedge clk);
    mem_addr = a;
    #1 push(1, {6'b0, e}, r);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    io_read(8'h23, 8'h00, "R1 reg0 after reset");
    map_check(20'hF0000, 2'b00, "R1 flags after reset");
    // R3 index port and undecoded port
    io_read(8'h22, 8'hFF, "R3 index port read");
    io_read(8'h40, 8'hFF, "R3 undecoded read");
    // R2 ordinary registers
    io_write(8'h22, 8'h10); io_write(8'h23, 8'h5A);
    io_write(8'h22, 8'h20); io_write(8'h23, 8'hC3);
    io_write(8'h22, 8'h10);
    io_read(8'h23, 8'h5A, "R2 reg 0x10");
    io_read(8'h23, 8'h5A, "R2 repeat read");
    io_write(8'h40, 8'h11);
    io_read(8'h23, 8'h5A, "R3 undecoded write ignored");
    io_write(8'h22, 8'h20);
    io_read(8'h23, 8'hC3, "R2 reg 0x20");
    // R4/R5 concealed bytes read from reset
    io_write(8'h22, 8'h83);
    io_read(8'h23, 8'h00, "R4 slot0 reset");
    io_read(8'h23, 8'h00, "R4 slot1 reset");
    io_read(8'h23, 8'hFF, "R5 exhausted read");
    // R6/R7/R8 commit on second write
    io_write(8'h22, 8'h83);
    io_write(8'h23, 8'h0A);
    map_check(20'hE0000, 2'b00, "R6 no change after first write");
    io_write(8'h23, 8'h40);
    map_check(20'hE0000, 2'b11, "R6 R8 128K window applied");
    map_check(20'hF8000, 2'b11, "R7 both flags");
    map_check(20'hD0000, 2'b00, "R9 below window");
    io_write(8'h23, 8'h00);
    map_check(20'hE0000, 2'b11, "R5 third write ignored");
    io_write(8'h22, 8'h83);
    io_read(8'h23, 8'h0A, "R4 slot0 readback");
    io_read(8'h23, 8'h40, "R4 slot1 readback");
    io_read(8'h23, 8'hFF, "R5 after readback");
    // R8 bit0 no effect, 64K window
    io_write(8'h22, 8'h83);
    io_write(8'h23, 8'h03); io_write(8'h23, 8'h00);
    map_check(20'hE0000, 2'b00, "R8 64K excludes E0000");
    map_check(20'hF0000, 2'b01, "R7 R8 write only, bit0 ignored");
    // R7 read only
    io_write(8'h22, 8'h83);
    io_write(8'h23, 8'h00); io_write(8'h23, 8'h40);
    map_check(20'hFFFFF, 2'b10, "R7 read only");
    // R10 simultaneous read and write
    io_write(8'h22, 8'h83);
    @(negedge clk);
    io_addr = 8'h23; io_wdata = 8'h08; io_wr = 1'b1; io_rd = 1'b1;
    #1 push(0, 8'h00, "R10 read returns old slot0");
    @(negedge clk);
    io_wr = 1'b0; io_rd = 1'b0;
    io_write(8'h23, 8'h40);
    map_check(20'hE0000, 2'b10, "R10 second slot committed");
    io_write(8'h22, 8'h83);
    io_read(8'h23, 8'h08, "R10 write stored");
    // R6 decode in the commit cycle sees old mapping
    io_write(8'h22, 8'h83);
    io_write(8'h23, 8'h02);
    @(negedge clk);
    mem_addr = 20'hF0000; io_addr = 8'h23; io_wdata = 8'h00; io_wr = 1'b1;
    #1 push(1, 8'h02, "R6 old mapping during commit");
    @(negedge clk);
    io_wr = 1'b0;
    #1 push(1, 8'h01, "R6 new mapping after commit");
    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule